// File: doc/BRIEF.md
# Reset Sequencer with Pin Filter and Boot Capture

This block merges three reset sources into one active-low internal reset for the rest of the chip. The three sources are:

- a power-on indication, which also serves as the block's own asynchronous reset;
- a supply-good flag from a low-voltage detector;
- an active-low external reset pin.

After power-on, the block keeps the internal reset asserted for a fixed number of reference clock cycles. A loss of supply holds reset, and reset stays held until the supply has been good for a separate settling interval. The external pin is synchronised and measured. Only a low level that lasts a minimum number of cycles causes a warm reset. Shorter glitches are discarded.

At the moment reset is released, the block samples an active-low boot-select pin. It keeps the result as a single-boot flag until the next release. A cause field records whether the last reset came from power-on, from the voltage detector or from the pin. Only a power-on clears this field.

Top module: `rst_seq_top`

## Requirements
- R1: After `rst_ni` rises, `sys_rst_no` stays low for INIT_CYCLES clock edges. It goes high on edge INIT_CYCLES+1 when no other source holds it.
- R2: If the reset pin rises before the initialisation interval ends, release still waits for the full interval.
- R3: If the reset pin is still low after the initialisation interval, release waits until the pin is high again. Release then happens within 3 cycles of the rise.
- R4: While `lvd_ok_i` is low, `sys_rst_no` is low. A drop of `lvd_ok_i` during operation pulls `sys_rst_no` low within 3 cycles.
- R5: After `lvd_ok_i` returns high, release needs at least LVD_REL_CYCLES consecutive good cycles, plus the synchroniser and state delay of at most 4 cycles.
- R6: A low pulse on `pin_rst_ni` that is shorter than PIN_MIN_CYCLES cycles has no effect on `sys_rst_no` or `cause_o`.
- R7: A low pulse on `pin_rst_ni` of PIN_MIN_CYCLES cycles or longer causes a warm reset. The reset is held for as long as the pin stays low.
- R8: At each release, `boot_single_o` takes the inverse of `boot_sel_ni` (pin low gives 1). It holds that value while reset stays released.
- R9: The `cause_o` encoding is: 2'b00 power-on, 2'b01 low voltage, 2'b10 pin. `warm_o` is 1 only for the pin cause. The field changes only when reset is entered from operation, and only `rst_ni` clears it to 2'b00.
- R10: While `rst_ni` is low, `sys_rst_no`=0, `cause_o`=2'b00, `boot_single_o`=0 and `warm_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Power-on indication, active low, asynchronous |
| lvd_ok_i | input | 1 | Supply above threshold (1 = good) |
| pin_rst_ni | input | 1 | External reset pin, active low, asynchronous |
| boot_sel_ni | input | 1 | Boot-select pin, low selects single boot |
| sys_rst_no | output | 1 | Internal reset, active low |
| boot_single_o | output | 1 | Single-boot mode captured at release |
| cause_o | output | 2 | Cause of last reset |
| warm_o | output | 1 | Last reset was a warm (pin) reset |

## Verification
The assertions assume the following about the inputs:

- The pin and supply-good inputs change no faster than the reference clock.
- The boot-select pin is stable for a few cycles before each release, so the synchronised copy matches the pin when it is captured.

The stimulus changes every input on the falling clock edge, and holds boot-select for many cycles around each release. Pulse widths are whole cycle counts, which places the filter boundary exactly at PIN_MIN_CYCLES-1 and PIN_MIN_CYCLES.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;
  typedef enum logic [1:0] {
    CAUSE_POR = 2'b00,
    CAUSE_LVD = 2'b01,
    CAUSE_PIN = 2'b10
  } cause_e;

  typedef enum logic {
    ST_HOLD = 1'b0,
    ST_RUN  = 1'b1
  } seq_st_e;
endpackage

// File: rtl/rst_seq_sync.sv
module rst_seq_sync #(
  parameter int unsigned W       = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/rst_seq_cnt.sv
// Saturating interval counter: clears on clr_i, counts while en_i, done at LIMIT.
module rst_seq_cnt #(
  parameter int unsigned LIMIT = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  output logic done_o
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (clr_i)              cnt_q <= '0;
    else if (en_i && cnt_q != LIM) cnt_q <= cnt_q + CW'(1);
  end

  assign done_o = (cnt_q == LIM);

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LIM); // R6
endmodule

// File: rtl/rst_seq_top.sv
module rst_seq_top
  import rst_seq_pkg::*;
#(
  parameter int unsigned INIT_CYCLES    = 64,
  parameter int unsigned LVD_REL_CYCLES = 32,
  parameter int unsigned PIN_MIN_CYCLES = 16,
  parameter int unsigned SYNC_STAGES    = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       lvd_ok_i,
  input  logic       pin_rst_ni,
  input  logic       boot_sel_ni,
  output logic       sys_rst_no,
  output logic       boot_single_o,
  output logic [1:0] cause_o,
  output logic       warm_o
);
  // {pin, boot, lvd}: pin and boot idle high, supply assumed bad at power-on
  localparam logic [2:0] SYNC_RST = 3'b110;

  logic [2:0] raw_in, syn_in;
  logic       pin_s, boot_s, lvd_s;
  logic       init_done, lvd_done, pin_done;
  seq_st_e    st_q;
  cause_e     cause_q;
  logic       boot_q;

  assign raw_in = {pin_rst_ni, boot_sel_ni, lvd_ok_i};

  rst_seq_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk_i (clk_i), .rst_ni (rst_ni), .d_i (raw_in), .q_o (syn_in)
  );
  assign {pin_s, boot_s, lvd_s} = syn_in;

  rst_seq_cnt #(.LIMIT(INIT_CYCLES)) u_init_cnt (
    .clk_i (clk_i), .rst_ni (rst_ni), .clr_i (1'b0), .en_i (1'b1), .done_o (init_done)
  );

  rst_seq_cnt #(.LIMIT(LVD_REL_CYCLES)) u_lvd_cnt (
    .clk_i (clk_i), .rst_ni (rst_ni), .clr_i (!lvd_s), .en_i (lvd_s), .done_o (lvd_done)
  );

  rst_seq_cnt #(.LIMIT(PIN_MIN_CYCLES)) u_pin_cnt (
    .clk_i (clk_i), .rst_ni (rst_ni), .clr_i (pin_s), .en_i (!pin_s), .done_o (pin_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_HOLD;
      cause_q <= CAUSE_POR;
      boot_q  <= 1'b0;
    end else begin
      unique case (st_q)
        ST_HOLD: begin
          if (init_done && lvd_done && lvd_s && pin_s) begin
            st_q   <= ST_RUN;
            boot_q <= !boot_s;
          end
        end
        ST_RUN: begin
          if (!lvd_s) begin
            st_q    <= ST_HOLD;
            cause_q <= CAUSE_LVD;
          end else if (pin_done) begin
            st_q    <= ST_HOLD;
            cause_q <= CAUSE_PIN;
          end
        end
        default: st_q <= ST_HOLD;
      endcase
    end
  end

  assign sys_rst_no    = (st_q == ST_RUN);
  assign boot_single_o = boot_q;
  assign cause_o       = cause_q;
  assign warm_o        = (cause_q == CAUSE_PIN);

  AST_INIT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_no |-> init_done); // R1
  AST_LVD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_no |-> lvd_done); // R5
  AST_SHORT_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sys_rst_no && !pin_done && lvd_s) |=> sys_rst_no); // R6
  AST_BOOT_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sys_rst_no && $past(sys_rst_no)) |-> $stable(boot_single_o)); // R8
  AST_CAUSE_ON_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cause_o) |-> $fell(sys_rst_no)); // R9
endmodule

// File: tb/tb_rst_seq_top.sv
module tb_rst_seq_top;
  localparam int unsigned INIT = 64;
  localparam int unsigned LVDR = 32;
  localparam int unsigned PMIN = 16;
  localparam int NV = 5;
  localparam int unsigned VEC_W [NV] = '{1, PMIN-2, PMIN-1, PMIN, PMIN+4};
  localparam bit          VEC_E [NV] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1};

  logic clk = 1'b0;
  logic rst_ni, lvd_ok_i, pin_rst_ni, boot_sel_ni;
  logic sys_rst_no, boot_single_o, warm_o;
  logic [1:0] cause_o;
  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rst_seq_top #(.INIT_CYCLES(INIT), .LVD_REL_CYCLES(LVDR), .PIN_MIN_CYCLES(PMIN)) dut (
    .clk_i (clk), .rst_ni (rst_ni), .lvd_ok_i (lvd_ok_i), .pin_rst_ni (pin_rst_ni),
    .boot_sel_ni (boot_sel_ni), .sys_rst_no (sys_rst_no), .boot_single_o (boot_single_o),
    .cause_o (cause_o), .warm_o (warm_o)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic por_start(input logic pin, input logic lvd);
    rst_ni = 1'b0; pin_rst_ni = pin; lvd_ok_i = lvd;
    tick(3);
    rst_ni = 1'b1;
  endtask

  task automatic warm_pulse(input int w);
    pin_rst_ni = 1'b0; tick(w); pin_rst_ni = 1'b1; tick(6);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog actual=hang expected=finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [1:0] exp_cause;
    bit saw_low;
    rst_ni = 1'b0; lvd_ok_i = 1'b1; pin_rst_ni = 1'b1; boot_sel_ni = 1'b1;
    tick(3);
    chk("R10 sys", sys_rst_no, 0);
    chk("R10 cause", cause_o, 0);
    chk("R10 boot", boot_single_o, 0);
    chk("R10 warm", warm_o, 0);

    // R1 initialisation interval
    rst_ni = 1'b1;
    tick(INIT);
    chk("R1 held", sys_rst_no, 0);
    tick(1);
    chk("R1 released", sys_rst_no, 1);
    chk("R9 cause por", cause_o, 2'b00);

    // Pulse-width vectors: R6 below minimum, R7 at and above
    exp_cause = 2'b00;
    for (int v = 0; v < NV; v++) begin
      saw_low = 1'b0;
      pin_rst_ni = 1'b0;
      for (int c = 0; c < int'(VEC_W[v]); c++) begin
        tick(1); if (!sys_rst_no) saw_low = 1'b1;
      end
      pin_rst_ni = 1'b1;
      for (int c = 0; c < 6; c++) begin
        tick(1); if (!sys_rst_no) saw_low = 1'b1;
      end
      if (VEC_E[v]) exp_cause = 2'b10;
      chk(VEC_E[v] ? "R7 pulse reset" : "R6 pulse ignored", saw_low, VEC_E[v]);
      chk("R6 R7 back up", sys_rst_no, 1);
      chk("R9 cause vec", cause_o, exp_cause);
    end

    // R7 held while pin low
    pin_rst_ni = 1'b0; tick(PMIN + 40);
    chk("R7 held", sys_rst_no, 0);
    chk("R9 warm", warm_o, 1);
    pin_rst_ni = 1'b1; tick(4);
    chk("R7 release", sys_rst_no, 1);

    // R8 boot capture
    boot_sel_ni = 1'b0;
    warm_pulse(PMIN + 6);
    chk("R8 single", boot_single_o, 1);
    boot_sel_ni = 1'b1; tick(10);
    chk("R8 stable", boot_single_o, 1);
    warm_pulse(PMIN + 6);
    chk("R8 normal", boot_single_o, 0);

    // R4 / R5 supply loss during operation
    lvd_ok_i = 1'b0; tick(3);
    chk("R4 assert", sys_rst_no, 0);
    chk("R9 cause lvd", cause_o, 2'b01);
    chk("R9 cold", warm_o, 0);
    tick(50);
    chk("R4 held", sys_rst_no, 0);
    lvd_ok_i = 1'b1; tick(LVDR);
    chk("R5 delay", sys_rst_no, 0);
    tick(4);
    chk("R5 release", sys_rst_no, 1);
    warm_pulse(PMIN - 2);
    chk("R6 cause kept", cause_o, 2'b01);

    // R9 cleared by power-on only
    rst_ni = 1'b0; tick(2);
    chk("R9 cleared", cause_o, 2'b00);
    chk("R10 sys again", sys_rst_no, 0);

    // R2 pin rises early during init
    por_start(1'b0, 1'b1);
    tick(10); pin_rst_ni = 1'b1; tick(INIT - 10);
    chk("R2 held", sys_rst_no, 0);
    tick(1);
    chk("R2 released", sys_rst_no, 1);

    // R3 pin held past init
    por_start(1'b0, 1'b1);
    tick(INIT + 30);
    chk("R3 held", sys_rst_no, 0);
    pin_rst_ni = 1'b1; tick(4);
    chk("R3 released", sys_rst_no, 1);
    chk("R9 cause after R3", cause_o, 2'b00);

    // R4 supply bad across power-on
    por_start(1'b1, 1'b0);
    tick(INIT + 20);
    chk("R4 cold held", sys_rst_no, 0);
    lvd_ok_i = 1'b1; tick(LVDR + 4);
    chk("R5 cold release", sys_rst_no, 1);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule